// File: doc/BRIEF.md
# Paged Firmware Download Sequencer

This block loads a firmware image into a microcontroller's program memory without software help. A requester pulses `start` with the image length and two options: strip a 32-byte header, and pad the length up to a whole number of 32-bit words. The image then arrives on a valid/ready byte stream. The block reaches the target only through a plain register-write port and two readback buses. The program memory is seen through a fixed window of `PAGE_BYTES` bytes, so the block selects each page in a control register before it writes that page's contents.

A run has four stages. First comes arbitration with a second requester, through a shared in-progress flag. Next the enable writes. Then the copy: whole words at rising 4-byte offsets from the window base, and single bytes for a final 1 to 3 byte tail. Last, the block drops the enable, polls a checksum-good flag with a bounded count, and sets a ready bit. If the ready bit is already set at the start, nothing is written.

Stream rules: a byte moves on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` is high only while the block is consuming header or image bytes. The source may drop `s_valid` at any time, and the block simply waits. The block never takes more than `img_len` bytes. Padding bytes are made inside the block and are never taken from the stream.

Top module: `fwdl_sequencer`

## Requirements
- R1: When `start` arrives and control bit 1 (ready) of `dlctl_rd` is already set, the block pulses `done` with `err_code` 0. It makes no register write, takes no stream byte and never raises `busy_out`.
- R2: While `peer_busy` is high, the block polls once per cycle for up to `WAIT_POLLS` polls. If the ready bit appears during this wait, it finishes as in R1. If `peer_busy` drops, or the poll limit is reached, it claims the download.
- R3: `busy_out` (the block's own in-progress flag) rises when the block claims the download. It stays high through the checksum stage and is low in the cycle where `done` pulses. Every register write and every stream transfer happens while it is high. After reset it is low.
- R4: The effective length depends on the two options. With `hdr_en`, the first min(32, `img_len`) stream bytes are read and discarded. With `pad_en`, the remaining length is rounded up to a multiple of 4 with zero bytes.
- R5: If the effective length exceeds `MAX_PAGES`*`PAGE_BYTES`, the block ends with `err_code` 1. In that case it makes no register write and takes no stream byte.
- R6: Before the copy, the block makes three writes in order: bit 10 (lane 1) of the system-function register is set, then control bit 0 (enable, lane 0) is set, then control bit 19 (lane 2) is cleared. Every other bit of each written lane is kept from the readback.
- R7: Before each page, the block writes lane 2 of the control register. Bits 18:16 take the page index, counting from 0. Bit 19 is 0, and bits 23:20 keep their readback value. The final partial page uses the next index.
- R8: The block writes each whole word with byte enables 1111 at `WIN_BASE` plus its offset within the page. Lane k carries image byte 4n+k.
- R9: A final tail of 1 to 3 bytes goes out as single-byte writes to `WIN_BASE` plus the byte's page offset. The byte enable is lane addr[1:0], and the byte is replicated on all lanes.
- R10: After the copy, the block writes lane 0 of the control register with only bit 0 cleared. Lane 1 (bit 15 holds another status) is never written.
- R11: The block polls control bit 2 (checksum good) for up to `CHK_POLLS` cycles. On success it writes lane 0 with bit 1 (ready) set and ends with `err_code` 0. On timeout it ends with `err_code` 2 and does not set the ready bit.
- R12: `s_ready` is high only during header or image consumption. Gaps in `s_valid` stall the block without loss. Exactly `img_len` bytes are taken on a successful run.
- R13: `done` is a one-cycle pulse. `err_code` holds its value until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a download, sampled in idle |
| img_len | input | LEN_W | Stream length in bytes, header included |
| hdr_en | input | 1 | Image carries a 32-byte header to skip |
| pad_en | input | 1 | Round the effective length up to a multiple of 4 |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Block accepts the stream byte |
| wr_valid | output | 1 | One-cycle register write strobe |
| wr_addr | output | ADDR_W | Byte address of the write |
| wr_be | output | 4 | Byte-lane enables |
| wr_data | output | 32 | Write data |
| sysfn_rd | input | 32 | Readback of the system-function register |
| dlctl_rd | input | 32 | Readback of the download control register |
| peer_busy | input | 1 | In-progress flag of the other requester |
| busy_out | output | 1 | This block's in-progress flag |
| done | output | 1 | Run finished, one-cycle pulse |
| err_code | output | 2 | 0 ok, 1 too many pages, 2 checksum timeout |

## Verification
The length sweep covers every stream length from 0 to 40 and the bands around the page-capacity limit, with and without header and padding. Each length has its own word count, tail size and last-page index, so a wrong tail split, a missing pad or a header off-by-one shows up as misplaced or untouched bytes in the modelled window. Throttled and gap-free streams separate correct back-pressure from dropped or repeated bytes. Separate runs cover the other cases: the peer flag dropping early versus held past the poll limit, the ready bit appearing mid-wait, and a checksum flag that arrives late versus never. These runs tell apart claiming, skipping and the two ending codes.

// File: rtl/fwdl_pkg.sv
package fwdl_pkg;
  localparam int FWDL_HDR_BYTES = 32;
  localparam int DL_EN_BIT  = 0;
  localparam int DL_RDY_BIT = 1;
  localparam int DL_CHK_BIT = 2;
  localparam int DL_CLR_BIT = 19;
  localparam int SYS_EN_BIT = 10;

  typedef enum logic [3:0] {
    S_IDLE, S_PROBE, S_WAITPEER, S_CLAIM, S_HDR, S_EN_SYS, S_EN_DL,
    S_EN_CLR, S_PAGESEL, S_DATA, S_DIS, S_POLL, S_SETRDY, S_FINISH
  } fwdl_state_e;

  typedef enum logic [1:0] {
    FWDL_OK = 2'd0, FWDL_ERR_PAGES = 2'd1, FWDL_ERR_CHK = 2'd2
  } fwdl_err_e;
endpackage

// File: rtl/fwdl_len_calc.sv
module fwdl_len_calc #(
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 4096,
  parameter int MAX_PAGES  = 8,
  localparam int POS_W     = LEN_W + 1
) (
  input  logic [LEN_W-1:0] img_len,
  input  logic             hdr_en,
  input  logic             pad_en,
  output logic [LEN_W-1:0] hdr_n,
  output logic [LEN_W-1:0] raw_n,
  output logic [POS_W-1:0] pad_n,
  output logic             too_big
);
  localparam int CAP = MAX_PAGES * PAGE_BYTES;
  localparam logic [LEN_W-1:0] HDR = LEN_W'(fwdl_pkg::FWDL_HDR_BYTES);

  logic [POS_W-1:0] ext;

  always_comb begin
    if (!hdr_en)            hdr_n = '0;
    else if (img_len < HDR) hdr_n = img_len;
    else                    hdr_n = HDR;
    raw_n = img_len - hdr_n;
    ext   = {1'b0, raw_n};
    pad_n = pad_en ? ((ext + POS_W'(3)) & ~POS_W'(3)) : ext;
    too_big = ({1'b0, pad_n} > (POS_W + 1)'(CAP));
  end
endmodule

// File: rtl/fwdl_poll_cnt.sv
module fwdl_poll_cnt #(
  parameter int LIMIT = 1000,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (!last)     cnt <= cnt + CW'(1);
  end

  assign last = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/fwdl_byte_src.sv
module fwdl_byte_src (
  input  logic       take,
  input  logic       pad_zero,
  input  logic       s_valid,
  input  logic [7:0] s_data,
  output logic       s_ready,
  output logic       byte_ok,
  output logic [7:0] byte_val
);
  assign s_ready  = take && !pad_zero;
  assign byte_ok  = take && (pad_zero || s_valid);
  assign byte_val = pad_zero ? 8'h00 : s_data;
endmodule

// File: rtl/fwdl_sequencer.sv
module fwdl_sequencer
  import fwdl_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 4096,
  parameter int MAX_PAGES  = 8,
  parameter int WAIT_POLLS = 5000,
  parameter int CHK_POLLS  = 1000,
  parameter logic [ADDR_W-1:0] SYSFN_ADDR = 'h0000,
  parameter logic [ADDR_W-1:0] DLCTL_ADDR = 'h0080,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  img_len,
  input  logic              hdr_en,
  input  logic              pad_en,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  output logic              s_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [3:0]        wr_be,
  output logic [31:0]       wr_data,
  input  logic [31:0]       sysfn_rd,
  input  logic [31:0]       dlctl_rd,
  input  logic              peer_busy,
  output logic              busy_out,
  output logic              done,
  output logic [1:0]        err_code
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int POS_W  = LEN_W + 1;

  fwdl_state_e      state;
  logic [LEN_W-1:0] cfg_len;
  logic             cfg_hdr, cfg_pad;
  logic [LEN_W-1:0] hdr_n, raw_n, hcnt;
  logic [POS_W-1:0] pad_n, pos, pos_inc, remain;
  logic             too_big, wait_last, chk_last;
  logic             take, pad_zero, byte_ok, tail;
  logic [7:0]       byte_val;
  logic [23:0]      word_buf;
  logic [2:0]       page;
  logic [PAGE_W-1:0] off;

  fwdl_len_calc #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .MAX_PAGES(MAX_PAGES)) u_len (
    .img_len(cfg_len), .hdr_en(cfg_hdr), .pad_en(cfg_pad),
    .hdr_n(hdr_n), .raw_n(raw_n), .pad_n(pad_n), .too_big(too_big));

  fwdl_poll_cnt #(.LIMIT(WAIT_POLLS)) u_wait (
    .clk(clk), .rst_n(rst_n), .run(state == S_WAITPEER), .last(wait_last));

  fwdl_poll_cnt #(.LIMIT(CHK_POLLS)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(state == S_POLL), .last(chk_last));

  assign take     = (state == S_HDR) || (state == S_DATA);
  assign pad_zero = (state == S_DATA) && (pos >= {1'b0, raw_n});

  fwdl_byte_src u_src (
    .take(take), .pad_zero(pad_zero), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .byte_ok(byte_ok), .byte_val(byte_val));

  assign pos_inc = pos + POS_W'(1);
  assign remain  = pad_n - {pos[POS_W-1:2], 2'b00};
  assign tail    = remain < POS_W'(4);
  assign page    = pos[PAGE_W +: 3];
  assign off     = pos[PAGE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cfg_len  <= '0;
      cfg_hdr  <= 1'b0;
      cfg_pad  <= 1'b0;
      hcnt     <= '0;
      pos      <= '0;
      word_buf <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_be    <= '0;
      wr_data  <= '0;
      busy_out <= 1'b0;
      done     <= 1'b0;
      err_code <= FWDL_OK;
    end else begin
      wr_valid <= 1'b0;
      done     <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          cfg_len  <= img_len;
          cfg_hdr  <= hdr_en;
          cfg_pad  <= pad_en;
          err_code <= FWDL_OK;
          state    <= S_PROBE;
        end
        S_PROBE: begin
          if (dlctl_rd[DL_RDY_BIT]) state <= S_FINISH;
          else if (peer_busy)       state <= S_WAITPEER;
          else                      state <= S_CLAIM;
        end
        S_WAITPEER: begin
          if (dlctl_rd[DL_RDY_BIT])         state <= S_FINISH;
          else if (!peer_busy || wait_last) state <= S_CLAIM;
        end
        S_CLAIM: begin
          busy_out <= 1'b1;
          hcnt     <= '0;
          if (too_big) begin
            err_code <= FWDL_ERR_PAGES;
            state    <= S_FINISH;
          end else if (hdr_n != '0) state <= S_HDR;
          else                      state <= S_EN_SYS;
        end
        S_HDR: if (byte_ok) begin
          hcnt <= hcnt + LEN_W'(1);
          if (hcnt + LEN_W'(1) == hdr_n) state <= S_EN_SYS;
        end
        S_EN_SYS: begin
          wr_valid <= 1'b1;
          wr_addr  <= SYSFN_ADDR;
          wr_be    <= 4'b0010;
          wr_data  <= sysfn_rd | (32'd1 << SYS_EN_BIT);
          state    <= S_EN_DL;
        end
        S_EN_DL: begin
          wr_valid <= 1'b1;
          wr_addr  <= DLCTL_ADDR;
          wr_be    <= 4'b0001;
          wr_data  <= dlctl_rd | (32'd1 << DL_EN_BIT);
          state    <= S_EN_CLR;
        end
        S_EN_CLR: begin
          wr_valid <= 1'b1;
          wr_addr  <= DLCTL_ADDR;
          wr_be    <= 4'b0100;
          wr_data  <= dlctl_rd & ~(32'd1 << DL_CLR_BIT);
          pos      <= '0;
          state    <= (pad_n == '0) ? S_DIS : S_PAGESEL;
        end
        S_PAGESEL: begin
          wr_valid <= 1'b1;
          wr_addr  <= DLCTL_ADDR;
          wr_be    <= 4'b0100;
          wr_data  <= {dlctl_rd[31:20], 1'b0, page, dlctl_rd[15:0]};
          state    <= S_DATA;
        end
        S_DATA: if (byte_ok) begin
          if (tail) begin
            wr_valid <= 1'b1;
            wr_addr  <= WIN_BASE + ADDR_W'(off);
            wr_be    <= 4'b0001 << pos[1:0];
            wr_data  <= {4{byte_val}};
          end else if (pos[1:0] == 2'd3) begin
            wr_valid <= 1'b1;
            wr_addr  <= WIN_BASE + ADDR_W'({off[PAGE_W-1:2], 2'b00});
            wr_be    <= 4'b1111;
            wr_data  <= {byte_val, word_buf};
          end else begin
            word_buf[pos[1:0]*8 +: 8] <= byte_val;
          end
          pos <= pos_inc;
          if (pos_inc == pad_n)                 state <= S_DIS;
          else if (pos_inc[PAGE_W-1:0] == '0)   state <= S_PAGESEL;
        end
        S_DIS: begin
          wr_valid <= 1'b1;
          wr_addr  <= DLCTL_ADDR;
          wr_be    <= 4'b0001;
          wr_data  <= dlctl_rd & ~(32'd1 << DL_EN_BIT);
          state    <= S_POLL;
        end
        S_POLL: begin
          if (dlctl_rd[DL_CHK_BIT]) state <= S_SETRDY;
          else if (chk_last) begin
            err_code <= FWDL_ERR_CHK;
            state    <= S_FINISH;
          end
        end
        S_SETRDY: begin
          wr_valid <= 1'b1;
          wr_addr  <= DLCTL_ADDR;
          wr_be    <= 4'b0001;
          wr_data  <= dlctl_rd | (32'd1 << DL_RDY_BIT);
          state    <= S_FINISH;
        end
        S_FINISH: begin
          busy_out <= 1'b0;
          done     <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fwdl_sequencer_chk.sv
module fwdl_sequencer_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DLCTL_ADDR = 'h0080,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 'h1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_ready,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [3:0]        wr_be,
  input logic              busy_out,
  input logic              done
);
  assert_wr_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy_out);
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy_out);
  assert_stream_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> busy_out);
  assert_be_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_be == 4'hF || $countones(wr_be) == 1));
  assert_word_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_be == 4'hF) |-> (wr_addr[1:0] == 2'b00 && wr_addr >= WIN_BASE));
  assert_status_lane_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == DLCTL_ADDR) |-> !wr_be[1]);
  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind fwdl_sequencer fwdl_sequencer_chk #(
  .ADDR_W(ADDR_W), .DLCTL_ADDR(DLCTL_ADDR), .WIN_BASE(WIN_BASE)
) u_fwdl_sequencer_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .wr_valid(wr_valid),
  .wr_addr(wr_addr), .wr_be(wr_be), .busy_out(busy_out), .done(done)
);

// File: tb/fwdl_sequencer_bench.sv
module fwdl_sequencer_bench;
  localparam int PB = 16, MP = 8, WP = 30, CP = 20, LW = 16, AW = 16;
  localparam int WSZ = PB * MP;
  localparam logic [15:0] A_SYS = 16'h0000, A_DL = 16'h0080, A_WIN = 16'h1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, hdr_en = 1'b0, pad_en = 1'b0, peer_busy = 1'b0;
  logic [LW-1:0] img_len = '0;
  logic s_valid, s_ready, wr_valid, busy_out, done;
  logic [7:0] s_data;
  logic [AW-1:0] wr_addr;
  logic [3:0] wr_be;
  logic [31:0] wr_data;
  logic [1:0] err_code;

  logic [31:0] sysfn_m, dlctl_m, ld_sys, ld_dl;
  logic [7:0] win [WSZ];
  logic ld = 1'b0, feed = 1'b0, gap = 1'b0, busy_seen;
  int ld_chk_d = 0, ld_rdy_d = 0, chk_t, rdy_t;
  int idx, tot = 0, cyc = 0, busy_cyc, nwords, nbytes, nbad, norder;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] img(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  assign s_valid = feed && (idx < tot) && !(gap && (cyc % 3 == 0));
  assign s_data  = img(idx);

  fwdl_sequencer #(.ADDR_W(AW), .LEN_W(LW), .PAGE_BYTES(PB), .MAX_PAGES(MP),
    .WAIT_POLLS(WP), .CHK_POLLS(CP), .SYSFN_ADDR(A_SYS), .DLCTL_ADDR(A_DL),
    .WIN_BASE(A_WIN)) u_fwdl_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len), .hdr_en(hdr_en),
    .pad_en(pad_en), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
    .sysfn_rd(sysfn_m), .dlctl_rd(dlctl_m), .peer_busy(peer_busy),
    .busy_out(busy_out), .done(done), .err_code(err_code));

  always @(posedge clk) begin
    int off, base;
    cyc <= cyc + 1;
    if (ld) begin
      sysfn_m <= ld_sys; dlctl_m <= ld_dl;
      for (int j = 0; j < WSZ; j++) win[j] <= 8'hEE;
      chk_t <= 0; rdy_t <= ld_rdy_d; idx <= 0;
      nwords <= 0; nbytes <= 0; nbad <= 0; norder <= 0; busy_seen <= 1'b0;
      busy_cyc <= 0;
    end else begin
      if (s_valid && s_ready) idx <= idx + 1;
      if (busy_out && !busy_seen) begin busy_seen <= 1'b1; busy_cyc <= cyc; end
      if (rdy_t != 0) begin rdy_t <= rdy_t - 1; if (rdy_t == 1) dlctl_m[1] <= 1'b1; end
      if (chk_t != 0) begin chk_t <= chk_t - 1; if (chk_t == 1) dlctl_m[2] <= 1'b1; end
      if (wr_valid) begin
        if (wr_addr == A_SYS) begin
          for (int k = 0; k < 4; k++) if (wr_be[k]) sysfn_m[8*k +: 8] <= wr_data[8*k +: 8];
        end else if (wr_addr == A_DL) begin
          for (int k = 0; k < 4; k++) if (wr_be[k]) dlctl_m[8*k +: 8] <= wr_data[8*k +: 8];
          if (wr_be == 4'b0001 && !wr_data[0] && ld_chk_d != 0 && chk_t == 0) chk_t <= ld_chk_d;
        end else if (wr_addr >= A_WIN && wr_addr < A_WIN + 16'(PB)) begin
          off  = int'(wr_addr - A_WIN);
          base = int'(dlctl_m[18:16]) * PB + (off & ~3);
          if (!dlctl_m[0] || !sysfn_m[10] || dlctl_m[19]) norder <= norder + 1;
          if (wr_be == 4'hF) nwords <= nwords + 1; else nbytes <= nbytes + 1;
          for (int k = 0; k < 4; k++) if (wr_be[k]) win[base + k] <= wr_data[8*k +: 8];
        end else nbad <= nbad + 1;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // len, header, pad, gap, control preset, checksum delay (0 = preset/never),
  // peer busy cycles (-1 = held), ready-later delay, expected error, expect skip
  task automatic run(int len, bit hdr, bit pad, bit g, logic [31:0] dl0, int chkd,
                     int peer, int rdyd, int exp_err, bit skip, output int rise);
    int hn, rn, pn, t, mism, lastpg;
    bit big, wrote;
    @(negedge clk);
    ld = 1'b1; ld_sys = 32'h0000_3200; ld_dl = dl0; ld_chk_d = chkd; ld_rdy_d = rdyd;
    @(negedge clk);
    ld = 1'b0; img_len = LW'(len); hdr_en = hdr; pad_en = pad; gap = g;
    tot = len; peer_busy = (peer != 0); start = 1'b1;
    t = cyc;
    @(negedge clk);
    start = 1'b0; feed = 1'b1;
    for (int c = 0; c < 4000 && !done; c++) begin
      if (peer > 0 && c == peer) peer_busy = 1'b0;
      @(negedge clk);
    end
    chk(done === 1'b1, "R13", "done seen", int'(done), 1);
    @(negedge clk);
    chk(done === 1'b0 && err_code == 2'(exp_err), "R13", "done pulse, err held", int'(err_code), exp_err);
    feed = 1'b0; peer_busy = 1'b0;
    rise = busy_cyc - t;
    hn = hdr ? (len < 32 ? len : 32) : 0;
    rn = len - hn;
    pn = pad ? (rn + 3) / 4 * 4 : rn;
    big = pn > WSZ;
    wrote = !skip && !big;
    chk(err_code == 2'(exp_err), "R5 R11", "err_code", int'(err_code), exp_err);
    mism = 0;
    for (int j = 0; j < WSZ; j++) begin
      logic [7:0] e;
      if (!wrote || j >= pn) e = 8'hEE;
      else if (j < rn)       e = img(hn + j);
      else                   e = 8'h00;
      if (win[j] !== e) mism++;
    end
    chk(mism == 0, "R4 R7 R8 R9", "window bytes wrong", mism, 0);
    chk(nwords == (wrote ? pn / 4 : 0), "R8", "word writes", nwords, wrote ? pn / 4 : 0);
    chk(nbytes == (wrote ? pn % 4 : 0), "R9", "tail byte writes", nbytes, wrote ? pn % 4 : 0);
    chk(idx == (wrote ? len : 0), "R12", "bytes taken", idx, wrote ? len : 0);
    chk(nbad == 0 && norder == 0, "R6", "stray or early writes", nbad + norder, 0);
    chk(busy_out == 1'b0 && busy_seen == !skip, "R3", "busy seen", int'(busy_seen), int'(!skip));
    if (wrote) begin
      lastpg = (pn == 0) ? 0 : (pn - 1) / PB;
      chk(dlctl_m[23:16] == {dl0[23:20], 1'b0, (pn == 0) ? dl0[18:16] : 3'(lastpg)}, "R7",
          "control lane 2", int'(dlctl_m[23:16]), int'({dl0[23:20], 1'b0, (pn == 0) ? dl0[18:16] : 3'(lastpg)}));
      chk(dlctl_m[15:8] == dl0[15:8] && dlctl_m[0] == 1'b0 && dlctl_m[1] == (exp_err == 0),
          "R10 R11", "control lanes 0/1", int'(dlctl_m[15:0]), int'(dl0[15:8]) * 256 + (exp_err == 0 ? 2 : 0));
      chk(sysfn_m == 32'h0000_3600, "R6", "sysfn", int'(sysfn_m), 32'h3600);
    end else begin
      chk(dlctl_m[31:2] == dl0[31:2] && dlctl_m[0] == dl0[0] && sysfn_m == 32'h3200,
          "R1 R5", "registers untouched", int'(dlctl_m), int'(dl0));
    end
  endtask

  initial begin
    #(20 * 200000);
    nfail++; nchk++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int r;
    repeat (3) @(negedge clk);
    chk(s_ready == 0 && wr_valid == 0 && busy_out == 0 && done == 0 && err_code == 0,
        "R3", "reset state", int'(busy_out), 0);
    rst_n = 1'b1;
    // length sweep, all header/pad combinations, gaps on odd lengths
    for (int len = 0; len <= 40; len++)
      for (int m = 0; m < 4; m++)
        run(len, m[0], m[1], len[0], 32'h00A8_8004, 0, 0, 0, 0, 0, r);
    // page-capacity boundary
    for (int len = 124; len <= 134; len++) begin
      run(len, 0, 1, 0, 32'h00A8_8004, 0, 0, 0,
          ((len + 3) / 4 * 4 > WSZ) ? 1 : 0, 0, r);
      run(len + 32, 1, 0, 1, 32'h00A8_8004, 0, 0, 0, (len > WSZ) ? 1 : 0, 0, r);
    end
    // R1: ready already set
    run(20, 0, 0, 0, 32'h00A8_8006, 0, 0, 0, 0, 1, r);
    // R2: peer drops early -> claim soon
    run(23, 0, 0, 0, 32'h00A8_8004, 0, 8, 0, 0, 0, r);
    chk(r < WP, "R2", "claim after peer drop", r, 12);
    // R2: peer held -> claim after poll limit
    run(23, 0, 0, 0, 32'h00A8_8004, 0, -1, 0, 0, 0, r);
    chk(r >= WP && r <= WP + 6, "R2", "claim after poll limit", r, WP + 3);
    // R2: ready appears during wait -> skip
    run(23, 0, 0, 0, 32'h00A8_8004, 0, -1, 6, 0, 1, r);
    // R11: late checksum -> ok; never -> timeout
    run(37, 0, 1, 1, 32'h00A8_8000, 4, 0, 0, 0, 0, r);
    run(37, 0, 1, 1, 32'h00A8_8000, 0, 0, 0, 2, 0, r);
    run(37, 0, 1, 1, 32'h00A8_8000, CP + 20, 0, 0, 2, 0, r);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule